// File: doc/BRIEF.md
# Coprocessor Interrupt Control and Status Register

This block is a single 16-bit control and status word that a host processor uses to manage an attached coprocessor. It keeps three interrupt sources: an audio-interface event, an auxiliary-memory DMA completion, and an interrupt raised by the coprocessor itself. Each source has a sticky pending bit and an enable (mask) bit. The block merges the enabled pending sources into one interrupt line toward the host.

The same word carries three coprocessor controls:
- a halt level;
- a reset request that issues a single-cycle pulse;
- a level that raises an interrupt toward the coprocessor.

The host reaches the word through a plain write/read port with an address. Each event producer drives a one-cycle pulse on its own input.

Top module: `cop_irq_csr`

## Requirements
- R1: After reset, every stored bit is 0. The read word is 0x0000 and `host_irq`, `cop_halt`, `cop_irq_req` and `cop_reset` are all low.
- R2: A pulse on an event input sets that source's pending bit, which then stays set. The pending bits are bit 3 (audio, `evt_audio`), bit 5 (memory DMA, `evt_dma`) and bit 7 (coprocessor, `evt_cop`).
- R3: Writing 1 to a pending bit clears it. Writing 0 to it leaves it unchanged. A write never sets a pending bit.
- R4: If an event arrives in the same cycle as a write-1 clear of that source, the event takes priority and the pending bit stays 1.
- R5: The enable bits are bit 4 (audio), bit 6 (memory) and bit 8 (coprocessor), and each reads back what was written. `host_irq` is high whenever some source has both its pending and enable bits set, and low otherwise.
- R6: Bit 2 is the halt control. It is read/write, and `cop_halt` follows its stored value.
- R7: Bit 1 is the host-to-coprocessor interrupt. It is read/write, and `cop_irq_req` follows its stored value.
- R8: Writing 1 to bit 0 drives `cop_reset` high for exactly one cycle, starting at the clock edge that accepts the write. Bit 0 always reads back as 0.
- R9: Bits 15 to 9 always read as 0, and writes to them have no effect.
- R10: The register answers only at address offset `REG_OFFSET` (default 0x0A). Writes to any other address change nothing, and reads of any other address return 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Register address, shared by writes and reads |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data for `addr`, combinational |
| evt_audio | input | 1 | Audio-interface event pulse |
| evt_dma | input | 1 | Auxiliary-memory DMA completion pulse |
| evt_cop | input | 1 | Coprocessor-raised interrupt pulse |
| host_irq | output | 1 | Merged interrupt toward the host |
| cop_halt | output | 1 | Halt level toward the coprocessor |
| cop_reset | output | 1 | One-cycle reset pulse toward the coprocessor |
| cop_irq_req | output | 1 | Interrupt level toward the coprocessor |

## Verification
The bench writes 1 to a pending bit in the same cycle as an event on that source. A design that gives the clear priority would lose that interrupt, and the read-back would show 0.

It writes words that include 0 in pending positions alongside new enable values. A design that stores the whole write word would drop pending interrupts or set pending bits by mistake.

It also checks the following:
- the reset pulse is exactly one cycle long, and bit 0 reads 0 afterwards;
- bits 15 to 9 cannot be set;
- writes to a neighbouring address leave the word untouched, which catches a decoder that matches too loosely.

// File: rtl/cop_csr_pkg.sv
package cop_csr_pkg;
   localparam int unsigned BIT_RST   = 0;
   localparam int unsigned BIT_CIRQ  = 1;
   localparam int unsigned BIT_HALT  = 2;
   localparam int unsigned SRC_BASE  = 3;
   localparam int unsigned SRC_COUNT = 3;
   localparam int unsigned FIELD_TOP = SRC_BASE + 2 * SRC_COUNT - 1;

   typedef enum logic [1:0] {
      SRC_AUDIO = 2'd0,
      SRC_DMA   = 2'd1,
      SRC_COP   = 2'd2
   } src_id_e;

   typedef struct packed {
      logic halt;
      logic irq_req;
   } cop_ctrl_t;

   function automatic int unsigned stat_pos(input int unsigned idx);
      return SRC_BASE + 2 * idx;
   endfunction

   function automatic int unsigned mask_pos(input int unsigned idx);
      return SRC_BASE + 2 * idx + 1;
   endfunction
endpackage

// File: rtl/cop_csr_decode.sv
module cop_csr_decode #(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned REG_OFFSET = 'h0A
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   output logic              hit,
   output logic              wr_hit
);
   localparam logic [ADDR_W-1:0] OFS = ADDR_W'(REG_OFFSET);

   assign hit    = (addr == OFS);
   assign wr_hit = hit & wr_en;
endmodule

// File: rtl/cop_csr_src_cell.sv
module cop_csr_src_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic wr_hit,
   input  logic wr_stat,
   input  logic wr_mask,
   output logic stat_q,
   output logic mask_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= 1'b0;
      end else if (evt) begin
         stat_q <= 1'b1;
      end else if (wr_hit && wr_stat) begin
         stat_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= 1'b0;
      end else if (wr_hit) begin
         mask_q <= wr_mask;
      end
   end
endmodule

// File: rtl/cop_csr_ctrl.sv
module cop_csr_ctrl
   import cop_csr_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr_hit,
   input  logic      wr_rst,
   input  logic      wr_cirq,
   input  logic      wr_halt,
   output cop_ctrl_t ctrl_q,
   output logic      rst_pulse_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_hit) begin
         ctrl_q.halt    <= wr_halt;
         ctrl_q.irq_req <= wr_cirq;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_pulse_q <= 1'b0;
      end else begin
         rst_pulse_q <= wr_hit & wr_rst;
      end
   end
endmodule

// File: rtl/cop_irq_csr.sv
module cop_irq_csr
   import cop_csr_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned REG_OFFSET = 'h0A,
   parameter bit          IRQ_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              evt_audio,
   input  logic              evt_dma,
   input  logic              evt_cop,
   output logic              host_irq,
   output logic              cop_halt,
   output logic              cop_reset,
   output logic              cop_irq_req
);
   localparam int unsigned NSRC  = SRC_COUNT;
   localparam int unsigned USED  = FIELD_TOP + 1;

   generate
      if (DATA_W < USED) begin : g_bad_width
         $error("DATA_W too small for field layout");
      end
      if (REG_OFFSET >= (1 << ADDR_W)) begin : g_bad_ofs
         $error("REG_OFFSET outside address range");
      end
   endgenerate

   logic            hit;
   logic            wr_hit;
   logic [NSRC-1:0] evt_vec;
   logic [NSRC-1:0] stat_q;
   logic [NSRC-1:0] mask_q;
   cop_ctrl_t       ctrl_q;
   logic            rst_pulse_q;
   logic [DATA_W-1:0] word;

   assign evt_vec[SRC_AUDIO] = evt_audio;
   assign evt_vec[SRC_DMA]   = evt_dma;
   assign evt_vec[SRC_COP]   = evt_cop;

   cop_csr_decode #(
      .ADDR_W     (ADDR_W),
      .REG_OFFSET (REG_OFFSET)
   ) u_dec (
      .addr   (addr),
      .wr_en  (wr_en),
      .hit    (hit),
      .wr_hit (wr_hit)
   );

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_src
         cop_csr_src_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt     (evt_vec[i]),
            .wr_hit  (wr_hit),
            .wr_stat (wr_data[stat_pos(i)]),
            .wr_mask (wr_data[mask_pos(i)]),
            .stat_q  (stat_q[i]),
            .mask_q  (mask_q[i])
         );
      end
   endgenerate

   cop_csr_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_hit      (wr_hit),
      .wr_rst      (wr_data[BIT_RST]),
      .wr_cirq     (wr_data[BIT_CIRQ]),
      .wr_halt     (wr_data[BIT_HALT]),
      .ctrl_q      (ctrl_q),
      .rst_pulse_q (rst_pulse_q)
   );

   always_comb begin
      word = '0;
      word[BIT_CIRQ] = ctrl_q.irq_req;
      word[BIT_HALT] = ctrl_q.halt;
      for (int unsigned k = 0; k < NSRC; k++) begin
         word[stat_pos(k)] = stat_q[k];
         word[mask_pos(k)] = mask_q[k];
      end
   end

   assign rd_data = hit ? word : '0;

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               irq_q <= 1'b0;
            end else begin
               irq_q <= |(stat_q & mask_q);
            end
         end
         assign host_irq = irq_q;
      end else begin : g_irq_comb
         assign host_irq = |(stat_q & mask_q);
      end
   endgenerate

   assign cop_halt    = ctrl_q.halt;
   assign cop_irq_req = ctrl_q.irq_req;
   assign cop_reset   = rst_pulse_q;
endmodule

// File: rtl/cop_irq_csr_chk.sv
module cop_irq_csr_chk
   import cop_csr_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned REG_OFFSET = 'h0A,
   parameter bit          IRQ_REG    = 1'b0
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 wr_en,
   input logic [ADDR_W-1:0]    addr,
   input logic [DATA_W-1:0]    wr_data,
   input logic [DATA_W-1:0]    rd_data,
   input logic [SRC_COUNT-1:0] evt_vec,
   input logic [SRC_COUNT-1:0] stat_q,
   input logic [SRC_COUNT-1:0] mask_q,
   input logic                 host_irq,
   input logic                 cop_reset
);
   logic wr_here;
   assign wr_here = wr_en && (addr == ADDR_W'(REG_OFFSET));

   AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      cop_reset |=> !cop_reset); // R8
   AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      cop_reset |-> $past(wr_here && wr_data[BIT_RST])); // R8
   AST_BIT0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[BIT_RST] == 1'b0); // R8
   AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[DATA_W-1:FIELD_TOP+1] == '0); // R9
   AST_MISS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (addr != ADDR_W'(REG_OFFSET)) |-> (rd_data == '0)); // R10

   generate
      for (genvar i = 0; i < SRC_COUNT; i++) begin : g_src_chk
         AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            evt_vec[i] |=> stat_q[i]); // R2
         AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stat_q[i]) |-> $past(evt_vec[i])); // R3
         AST_CLEAR_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_here && wr_data[stat_pos(i)] && evt_vec[i]) |=> stat_q[i]); // R4
         AST_HOLD_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_q[i] && !(wr_here && wr_data[stat_pos(i)])) |=> stat_q[i]); // R2
      end
      if (!IRQ_REG) begin : g_irq_chk
         AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
            host_irq |-> ((stat_q & mask_q) != '0)); // R5
         AST_IRQ_MASKED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_q == '0) |-> !host_irq); // R5
      end
   endgenerate
endmodule

bind cop_irq_csr cop_irq_csr_chk #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .REG_OFFSET (REG_OFFSET),
   .IRQ_REG    (IRQ_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .addr      (addr),
   .wr_data   (wr_data),
   .rd_data   (rd_data),
   .evt_vec   (evt_vec),
   .stat_q    (stat_q),
   .mask_q    (mask_q),
   .host_irq  (host_irq),
   .cop_reset (cop_reset)
);

// File: tb/sim_cop_irq_csr.sv
module sim_cop_irq_csr;
   localparam logic [7:0] OFS = 8'h0A;
   localparam int NV = 12;
   // {wr, addr, data, evt[2:0]=cop,dma,audio, expected word, expected irq}
   localparam logic [44:0] TAB [NV] = '{
      {1'b0, OFS,   16'h0000, 3'b001, 16'h0008, 1'b0}, // R2 audio event
      {1'b1, OFS,   16'h0010, 3'b000, 16'h0018, 1'b1}, // R3 write 0 keeps, R5 mask
      {1'b1, OFS,   16'h0018, 3'b000, 16'h0010, 1'b0}, // R3 write 1 clears
      {1'b0, OFS,   16'h0000, 3'b110, 16'h00B0, 1'b0}, // R2 dma+cop, masked
      {1'b1, OFS,   16'h0150, 3'b000, 16'h01F0, 1'b1}, // R5 all masks
      {1'b1, OFS,   16'h0170, 3'b000, 16'h01D0, 1'b1}, // R3 clear dma
      {1'b1, OFS,   16'h01D0, 3'b000, 16'h0150, 1'b0}, // R3 clear cop
      {1'b1, OFS,   16'h0156, 3'b000, 16'h0156, 1'b0}, // R6 R7 controls
      {1'b1, OFS,   16'hFF56, 3'b000, 16'h0156, 1'b0}, // R9 high bits
      {1'b1, 8'h0C, 16'h0000, 3'b000, 16'h0156, 1'b0}, // R10 other address
      {1'b1, OFS,   16'h0008, 3'b001, 16'h0008, 1'b0}, // R4 event beats clear
      {1'b1, OFS,   16'h0018, 3'b001, 16'h0018, 1'b1}  // R4 with mask
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = OFS;
   logic [15:0] wr_data = '0;
   logic [2:0]  evt = '0;
   logic [15:0] rd_data;
   logic        host_irq, cop_halt, cop_reset, cop_irq_req;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   cop_irq_csr u0 (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .addr (addr),
      .wr_data (wr_data), .rd_data (rd_data),
      .evt_audio (evt[0]), .evt_dma (evt[1]), .evt_cop (evt[2]),
      .host_irq (host_irq), .cop_halt (cop_halt),
      .cop_reset (cop_reset), .cop_irq_req (cop_irq_req)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(input logic w, input logic [7:0] a, input logic [15:0] d, input logic [2:0] e);
      @(negedge clk);
      wr_en = w; addr = a; wr_data = d; evt = e;
      @(posedge clk);
      #2 wr_en = 1'b0; evt = '0; addr = OFS;
      #3;
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #35;
      chk("R1 word in reset", rd_data, 16'h0000);
      chk("R1 outputs in reset", {12'h0, host_irq, cop_halt, cop_reset, cop_irq_req}, 16'h0000);
      @(negedge clk); rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         step(TAB[i][44], TAB[i][43:36], TAB[i][35:20], TAB[i][19:17]);
         chk($sformatf("vector %0d word", i), rd_data, TAB[i][16:1]);
         chk($sformatf("vector %0d R5 host_irq", i), {15'h0, host_irq}, {15'h0, TAB[i][0]});
         if (i == 8) begin
            chk("R6 cop_halt", {15'h0, cop_halt}, 16'h0001);
            chk("R7 cop_irq_req", {15'h0, cop_irq_req}, 16'h0001);
            @(negedge clk); addr = 8'h0B; #2;
            chk("R10 read other address", rd_data, 16'h0000);
            addr = OFS;
         end
      end
      chk("R6 halt released", {15'h0, cop_halt}, 16'h0000);
      chk("R7 request released", {15'h0, cop_irq_req}, 16'h0000);

      // R8 reset pulse: high for one cycle, reads back 0
      step(1'b1, OFS, 16'h0019, 3'b000);
      chk("R8 pulse first cycle", {15'h0, cop_reset}, 16'h0001);
      chk("R8 bit0 reads 0", rd_data, 16'h0010);
      @(posedge clk); #5;
      chk("R8 pulse ends", {15'h0, cop_reset}, 16'h0000);
      step(1'b1, 8'h0B, 16'h0001, 3'b000);
      chk("R10 no pulse off-address", {15'h0, cop_reset}, 16'h0000);

      // R1 reset mid-state
      step(1'b1, OFS, 16'h0156, 3'b111);
      @(negedge clk); rst_n = 1'b0; #2;
      chk("R1 reset clears word", rd_data, 16'h0000);
      chk("R1 reset clears outputs", {12'h0, host_irq, cop_halt, cop_reset, cop_irq_req}, 16'h0000);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule